// File: doc/BRIEF.md
# Programmable Parallel Port Controller

A CPU-facing controller for three 8-bit general-purpose ports named A, B and C. Port C is treated as two 4-bit halves. The ports form two groups. Group A owns port A and the upper half of C. Group B owns port B and the lower half of C. The CPU reaches the block over an 8-bit data path, an active-low select, active-low read and write strobes, and a 2-bit register address. The data path is split into `data_i`, `data_o` and `data_oe_o` so that the bidirectional pad can sit outside the block.

A control word sets the pin direction of each port or half-port. Each pin has an output value and an output enable. A second form of the control write sets or clears a single pin of port C without touching the others. Only plain latched-output and buffered-input operation is built. The group mode fields are stored and read back, but they do not change how the ports behave.

Top module: `ppi_top`

## Requirements
- R1: After reset, every output enable is 0, every output latch is 0, and a read of address 11 returns 0x9B.
- R2: While `cs_ni` is high, writes have no effect and `data_oe_o` stays low.
- R3: Address 00 selects port A, 01 selects port B, 10 selects port C and 11 selects the control register. A write stores the data into the selected latch on the next clock edge.
- R4: A write to address 11 with bit 7 set is a mode-set word. Its fields are: bit 0 lower C direction, bit 1 port B direction, bit 2 group B mode, bit 3 upper C direction, bit 4 port A direction, bits 6..5 group A mode. A direction of 1 means input. A read of address 11 returns this word with bit 7 set.
- R5: A mode-set write clears all three output latches to zero.
- R6: A write to address 11 with bit 7 clear changes only one bit of the port C latch. Bits 3..1 give the index and bit 0 gives the new value. The control word does not change.
- R7: A port read returns the latch on output-configured pins and the input pins on input-configured pins. Port C is decided per half.
- R8: A pin's output enable is 1 exactly when its port or half is configured as output. All bits of a port or half always match.
- R9: Any value of the group mode fields is accepted, stored and read back, while the ports keep basic latch/buffer behaviour.
- R10: `data_oe_o` is high exactly while `cs_ni` and `rd_ni` are low and `wr_ni` is high.
- R11: A write to a port configured as input still updates its latch, which appears on the port's output lines while the enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Register address |
| data_i | input | 8 | Write data from the CPU |
| data_o | output | 8 | Read data to the CPU |
| data_oe_o | output | 1 | Read data drive enable |
| pa_i | input | 8 | Port A input pins |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A per-pin output enable |
| pb_i | input | 8 | Port B input pins |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B per-pin output enable |
| pc_i | input | 8 | Port C input pins |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C per-pin output enable |

## Verification
The bench builds the block with the default package constants: 8-bit ports, 4-bit halves of port C, and a 3-bit set/reset index. With these values, a single-bit write can reach the top pin of C, and a mixed-direction configuration lets one port C read combine latch bits and pin bits. Each read's expected value is queued by the driver and compared when the read strobe is active. The sequence moves through reset, all-output, mixed-direction and nonzero-mode configurations, so the clearing on mode-set and the per-half multiplexing can be seen across those changes.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int PORT_W = 8;
  localparam int HALF_W = PORT_W / 2;
  localparam int NPORT  = 3;
  localparam int IDX_W  = $clog2(PORT_W);
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_A    = 2'b00,
    SEL_B    = 2'b01,
    SEL_C    = 2'b10,
    SEL_CTRL = 2'b11
  } sel_e;

  // out_* bits are 1 for output; the readback inverts them to direction bits
  typedef struct packed {
    logic [1:0] mode_a;
    logic       out_a;
    logic       out_cu;
    logic       mode_b;
    logic       out_b;
    logic       out_cl;
  } cfg_t;
endpackage

// File: rtl/ppi_bus_dec.sv
module ppi_bus_dec
  import ppi_pkg::*;
(
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NPORT-1:0]  port_wr_o,
  output logic              ctrl_wr_o,
  output logic              rd_o
);
  logic wr_act;

  assign wr_act = !cs_ni && !wr_ni;
  assign rd_o   = !cs_ni && !rd_ni && wr_ni;

  always_comb begin
    port_wr_o = '0;
    ctrl_wr_o = 1'b0;
    if (wr_act) begin
      unique case (sel_e'(addr_i))
        SEL_A:    port_wr_o[0] = 1'b1;
        SEL_B:    port_wr_o[1] = 1'b1;
        SEL_C:    port_wr_o[2] = 1'b1;
        SEL_CTRL: ctrl_wr_o    = 1'b1;
        default:  ;
      endcase
    end
  end

  always_comb begin
    AST_ONE_TARGET: assert ($countones({port_wr_o, ctrl_wr_o}) <= 1); // R3
  end
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [PORT_W-1:0] data_i,
  output cfg_t              cfg_o,
  output logic              mode_set_o,
  output logic              bsr_en_o,
  output logic [IDX_W-1:0]  bsr_idx_o,
  output logic              bsr_val_o
);
  cfg_t cfg_q;

  assign mode_set_o = wr_i && data_i[PORT_W-1];
  assign bsr_en_o   = wr_i && !data_i[PORT_W-1];
  assign bsr_idx_o  = data_i[IDX_W:1];
  assign bsr_val_o  = data_i[0];
  assign cfg_o      = cfg_q;

  // stored as output enables so that a cleared register means all inputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (mode_set_o) begin
      cfg_q.mode_a <= data_i[6:5];
      cfg_q.out_a  <= !data_i[4];
      cfg_q.out_cu <= !data_i[3];
      cfg_q.mode_b <= data_i[2];
      cfg_q.out_b  <= !data_i[1];
      cfg_q.out_cl <= !data_i[0];
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_set_o |=> $stable(cfg_q)); // R6
endmodule

// File: rtl/ppi_port_lat.sv
module ppi_port_lat #(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [W-1:0]  data_i,
  input  logic          bit_en_i,
  input  logic [IW-1:0] bit_idx_i,
  input  logic          bit_val_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (clr_i)    q <= '0;
    else if (wr_i)     q <= data_i;
    else if (bit_en_i) q[bit_idx_i] <= bit_val_i;
  end

  assign q_o = q;

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == '0)); // R5
  AST_BIT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !clr_i && !wr_i) |=> (q_o[$past(bit_idx_i)] == $past(bit_val_i))); // R6
  AST_LAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !wr_i && !bit_en_i) |=> $stable(q_o)); // R2
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] data_i,
  output logic [PORT_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [PORT_W-1:0] pa_i,
  output logic [PORT_W-1:0] pa_o,
  output logic [PORT_W-1:0] pa_oe_o,
  input  logic [PORT_W-1:0] pb_i,
  output logic [PORT_W-1:0] pb_o,
  output logic [PORT_W-1:0] pb_oe_o,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] pc_o,
  output logic [PORT_W-1:0] pc_oe_o
);
  logic [NPORT-1:0]  port_wr;
  logic              ctrl_wr;
  logic              rd_en;
  cfg_t              cfg;
  logic              mode_set;
  logic              bsr_en;
  logic [IDX_W-1:0]  bsr_idx;
  logic              bsr_val;
  logic [PORT_W-1:0] lat_q [NPORT];
  logic [PORT_W-1:0] ctrl_rb;

  ppi_bus_dec i_dec (
    .cs_ni     (cs_ni),
    .rd_ni     (rd_ni),
    .wr_ni     (wr_ni),
    .addr_i    (addr_i),
    .port_wr_o (port_wr),
    .ctrl_wr_o (ctrl_wr),
    .rd_o      (rd_en)
  );

  ppi_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctrl_wr),
    .data_i     (data_i),
    .cfg_o      (cfg),
    .mode_set_o (mode_set),
    .bsr_en_o   (bsr_en),
    .bsr_idx_o  (bsr_idx),
    .bsr_val_o  (bsr_val)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    ppi_port_lat #(.W(PORT_W)) i_lat (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (mode_set),
      .wr_i      (port_wr[p]),
      .data_i    (data_i),
      .bit_en_i  (bsr_en && (p == NPORT - 1)),
      .bit_idx_i (bsr_idx),
      .bit_val_i (bsr_val),
      .q_o       (lat_q[p])
    );
  end

  assign pa_o    = lat_q[0];
  assign pb_o    = lat_q[1];
  assign pc_o    = lat_q[2];
  assign pa_oe_o = {PORT_W{cfg.out_a}};
  assign pb_oe_o = {PORT_W{cfg.out_b}};
  assign pc_oe_o = {{HALF_W{cfg.out_cu}}, {HALF_W{cfg.out_cl}}};

  assign ctrl_rb = {1'b1, cfg.mode_a, !cfg.out_a, !cfg.out_cu,
                    cfg.mode_b, !cfg.out_b, !cfg.out_cl};

  always_comb begin
    data_o = '0;
    if (rd_en) begin
      unique case (sel_e'(addr_i))
        SEL_A:    data_o = (pa_o & pa_oe_o) | (pa_i & ~pa_oe_o);
        SEL_B:    data_o = (pb_o & pb_oe_o) | (pb_i & ~pb_oe_o);
        SEL_C:    data_o = (pc_o & pc_oe_o) | (pc_i & ~pc_oe_o);
        SEL_CTRL: data_o = ctrl_rb;
        default:  ;
      endcase
    end
  end

  assign data_oe_o = rd_en;

  AST_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !data_oe_o); // R2
  AST_NO_SEL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> ($stable(pa_o) && $stable(pb_o) && $stable(pc_o))); // R2
  AST_READ_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !rd_ni && wr_ni) |-> data_oe_o); // R10
  AST_OE_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pa_oe_o == '0) || (&pa_oe_o)) && ((pb_oe_o == '0) || (&pb_oe_o))); // R8
  AST_MODE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !wr_ni && addr_i == SEL_CTRL && data_i[PORT_W-1])
      |=> (pa_o == '0 && pb_o == '0 && pc_o == '0)); // R5
endmodule

// File: tb/test_ppi_top.sv
`timescale 1ns/1ps
module test_ppi_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_oe;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] pa_o, pb_o, pc_o, pa_oe, pb_oe, pc_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] data;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  ppi_top i_ppi_top (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(dout_oe),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe)
  );

  // monitor: compare each active read against the queued expectation
  always @(negedge clk) begin
    if (!cs_n && !rd_n && wr_n) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s read with empty queue: act %h exp none", "R3", dout);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (dout !== e.data || dout_oe !== 1'b1) begin
          errors++;
          $display("FAIL %s read: act %h oe %b exp %h oe 1", e.tag, dout, dout_oe, e.data);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
    @(posedge clk); #1;
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    exp_t it;
    @(posedge clk); #1;
    it.data = e; it.tag = tag;
    exp_q.push_back(it);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(posedge clk); #1;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: act %h exp %h", tag, act, e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    pa_i = 8'h5A;
    // R1 reset state
    @(negedge clk);
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 pb_o", pb_o, 8'h00);
    rd(2'b11, 8'h9B, "R1");
    rd(2'b00, 8'h5A, "R7");
    // all outputs, modes 0
    wr(2'b11, 8'h80);
    rd(2'b11, 8'h80, "R4");
    @(negedge clk);
    chk("R8 pa_oe", pa_oe, 8'hFF);
    chk("R8 pc_oe", pc_oe, 8'hFF);
    wr(2'b00, 8'h3C);
    wr(2'b01, 8'hA5);
    wr(2'b10, 8'h7E);
    rd(2'b00, 8'h3C, "R3");
    rd(2'b01, 8'hA5, "R3");
    rd(2'b10, 8'h7E, "R3");
    @(negedge clk);
    chk("R3 pb_o", pb_o, 8'hA5);
    // R2 deselected write and read
    @(posedge clk); #1;
    cs_n = 1'b1; wr_n = 1'b0; addr = 2'b00; din = 8'hFF;
    @(posedge clk); #1;
    wr_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    chk("R2 data_oe", {7'd0, dout_oe}, 8'h00);
    chk("R2 pa_o", pa_o, 8'h3C);
    @(posedge clk); #1 rd_n = 1'b1;
    // R6 single-bit set/clear on port C
    wr(2'b11, 8'h0F);
    wr(2'b11, 8'h00);
    @(negedge clk);
    chk("R6 pc_o", pc_o, 8'hFE);
    rd(2'b11, 8'h80, "R6");
    // R5 mode-set clears latches; mixed directions
    pb_i = 8'h33; pc_i = 8'h9C;
    wr(2'b11, 8'h8A);
    @(negedge clk);
    chk("R5 pa_o", pa_o, 8'h00);
    chk("R5 pc_o", pc_o, 8'h00);
    chk("R8 pb_oe", pb_oe, 8'h00);
    chk("R8 pc_oe mixed", pc_oe, 8'h0F);
    rd(2'b10, 8'h90, "R7");
    rd(2'b01, 8'h33, "R7");
    // R11 write to input port
    wr(2'b01, 8'h44);
    @(negedge clk);
    chk("R11 pb_o", pb_o, 8'h44);
    chk("R11 pb_oe", pb_oe, 8'h00);
    rd(2'b01, 8'h33, "R11");
    // R9 nonzero mode codes
    wr(2'b11, 8'hE5);
    rd(2'b11, 8'hE5, "R9");
    @(negedge clk);
    chk("R9 pc_oe", pc_oe, 8'hF0);
    chk("R9 pb_oe", pb_oe, 8'hFF);
    wr(2'b00, 8'h12);
    rd(2'b00, 8'h12, "R9");
    // R10 idle bus
    @(negedge clk);
    chk("R10 data_oe idle", {7'd0, dout_oe}, 8'h00);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 unconsumed reads: act %0d exp 0", exp_q.size());
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: act timeout exp completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule